// File: doc/BRIEF.md
# Cascaded 2-1 Sigma-Delta Noise Cancellation Combiner

This block is the digital recombination stage of a cascaded sigma-delta modulator. The front loop is second-order and the back loop is first-order. Each loop hands over one single-bit code per modulator clock, qualified by a valid strobe. The combiner delays the front-loop code by one sample. It runs the back-loop code through a squared first-difference filter and adds the two paths into one signed multi-level word. Because the back loop digitizes the front loop's quantization error, the sum contains no front-loop error. What remains is the input delayed by three samples plus back-loop error shaped to third order.

The history registers advance only on accepted samples, so the modulator clock can be gated through the strobe. The output word is registered, and its valid flag stays low until enough real samples have replaced the reset contents of the history. A downstream decimator consumes the word only while the output valid flag is high.

Top module: `mash21Recombine`

## Requirements
- R1: A synchronous active-high reset drives `outValid` low and `outWord` to 0 and fills every history register with the code for −1. `outValid` stays low for the first two accepted samples after reset and first rises for the third.
- R2: A stage bit of 1 stands for +1 and a stage bit of 0 stands for −1.
- R3: For an accepted sample n the word is y1[n−1] + y2[n] − 2·y2[n−1] + y2[n−2]. Here y1 is the front-loop value and y2 is the back-loop value, and the history holds only accepted samples.
- R4: `outWord` is a 4-bit two's-complement word (bit 3 is the sign). It reaches both +5 and −5 exactly, with no saturation or wrap.
- R5: A cycle with `inValid` low leaves the history unchanged. On the next cycle `outValid` is low and `outWord` holds its previous value.
- R6: The result for a sample accepted at a clock edge appears on `outWord` and `outValid` right after that same edge, so there is one register of latency.
- R7: When both stage bits are held at the same constant value, the output after fill is constant: +1 for all ones and −1 for all zeros.
- R8: Whenever `outValid` is high, `outWord` is odd (bit 0 set).
- R9: A reset asserted in the middle of a stream restarts the fill, so the next two accepted samples again give `outValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Both stage codes are valid this cycle |
| stage1Bit | input | 1 | Code from the second-order front loop |
| stage2Bit | input | 1 | Code from the first-order back loop |
| outValid | output | 1 | `outWord` holds a fully filled result |
| outWord | output | 4 | Combined signed word, two's complement |

## Verification
The hardest cases to reach are the two extreme words, ±5. Each needs a specific three-sample pattern on the back loop, 1,0,1 or 0,1,0, together with the matching front-loop bit one sample earlier. A random stream hits them only now and then. The stimulus therefore drives both patterns directly. It also spreads invalid cycles through a long random stream, so the history is checked across gaps, and it resets in the middle of a stream to make the fill start again.

// File: rtl/mash21_pkg.sv
`timescale 1ns/1ps
package mash21_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic shiftEn; // accept the current sample into history
    logic emit;    // this sample's result is fully filled
  } recombStrobe_t;
endpackage

// File: rtl/mash21Ctrl.sv
`timescale 1ns/1ps
module mash21Ctrl #(
  parameter int DIFF_ORDER = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output mash21_pkg::recombStrobe_t strobes
);
  // Samples needed before every history tap holds real data.
  localparam int FILL_LEN = DIFF_ORDER + 1;
  localparam int CNT_W    = $clog2(FILL_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FILL_LEN - 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (inValid && (fillCnt != FULL_CNT)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shiftEn = inValid;
    strobes.emit    = inValid && (fillCnt == FULL_CNT);
  end

  // R1
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (fillCnt != FULL_CNT) |=> (fillCnt <= FULL_CNT));
endmodule

// File: rtl/mash21Datapath.sv
`timescale 1ns/1ps
module mash21Datapath #(
  parameter int DIFF_ORDER = 2,
  parameter int OUT_W      = 4
) (
  input  logic clk,
  input  logic rst,
  input  mash21_pkg::recombStrobe_t strobes,
  input  logic stage1Bit,
  input  logic stage2Bit,
  output logic outValid,
  output logic signed [OUT_W-1:0] outWord
);
  localparam int TAPS    = DIFF_ORDER + 1;
  localparam int MAX_MAG = 1 + (1 << DIFF_ORDER);

  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

  // History: bit 0 means -1, so a cleared register holds the code for -1.
  logic                  y1Prev;
  logic [DIFF_ORDER-1:0] y2Prev;
  logic [TAPS-1:0]       y2Tap;
  int                    accInt;
  logic signed [OUT_W-1:0] nextWord;

  always_ff @(posedge clk) begin
    if (rst) y1Prev <= 1'b0;
    else if (strobes.shiftEn) y1Prev <= stage1Bit;
  end

  genvar g;
  generate
    for (g = 0; g < DIFF_ORDER; g++) begin : gHist
      if (g == 0) begin : gHead
        always_ff @(posedge clk) begin
          if (rst) y2Prev[0] <= 1'b0;
          else if (strobes.shiftEn) y2Prev[0] <= stage2Bit;
        end
      end else begin : gTail
        always_ff @(posedge clk) begin
          if (rst) y2Prev[g] <= 1'b0;
          else if (strobes.shiftEn) y2Prev[g] <= y2Prev[g-1];
        end
      end
    end
  endgenerate

  assign y2Tap = {y2Prev, stage2Bit};

  // Front path: one-sample delay; back path: (1 - z^-1)^DIFF_ORDER.
  always_comb begin
    int coef;
    accInt = y1Prev ? 1 : -1;
    for (int k = 0; k < TAPS; k++) begin
      coef = binom(DIFF_ORDER, k);
      if ((k % 2) == 1) coef = -coef;
      if (y2Tap[k]) accInt = accInt + coef;
      else          accInt = accInt - coef;
    end
    nextWord = accInt[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.emit;
      if (strobes.shiftEn) outWord <= nextWord;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |-> (accInt <= MAX_MAG && accInt >= -MAX_MAG));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> ($stable(outWord) && $stable(y1Prev) && $stable(y2Prev)));

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(strobes.shiftEn));
endmodule

// File: rtl/mash21Recombine.sv
`timescale 1ns/1ps
module mash21Recombine #(
  parameter int DIFF_ORDER = 2,
  parameter int OUT_W      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic stage1Bit,
  input  logic stage2Bit,
  output logic outValid,
  output logic signed [OUT_W-1:0] outWord
);
  mash21_pkg::recombStrobe_t strobes;

  mash21Ctrl #(.DIFF_ORDER(DIFF_ORDER)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes)
  );

  mash21Datapath #(.DIFF_ORDER(DIFF_ORDER), .OUT_W(OUT_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .stage1Bit (stage1Bit),
    .stage2Bit (stage2Bit),
    .outValid  (outValid),
    .outWord   (outWord)
  );

  // R8
  odd_word_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outWord[0]);
endmodule

// File: tb/tb_mash21Recombine.sv
`timescale 1ns/1ps
module tb_mash21Recombine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic stage1Bit = 1'b0;
  logic stage2Bit = 1'b0;
  logic outValid;
  logic signed [3:0] outWord;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  // reference model state
  int h1, h2a, h2b, fillN, lastWord;

  always #2.5 clk = ~clk;

  mash21Recombine dut (
    .clk(clk), .rst(rst), .inValid(inValid),
    .stage1Bit(stage1Bit), .stage2Bit(stage2Bit),
    .outValid(outValid), .outWord(outWord)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    h1 = -1; h2a = -1; h2b = -1; fillN = 0; lastWord = 0;
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    modelReset();
    check(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);
    check($signed(outWord) == 0, "R1 reset word", int'($signed(outWord)), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one cycle, then compare against the model.
  task automatic step(input logic v, input logic b1, input logic b2, input string tag);
    int c1, c2, expW;
    bit expV;
    inValid = v; stage1Bit = b1; stage2Bit = b2;
    @(posedge clk); #1;
    if (v) begin
      c1 = b1 ? 1 : -1;        // R2 mapping
      c2 = b2 ? 1 : -1;
      expW = h1 + c2 - 2 * h2a + h2b;
      expV = (fillN >= 2);
      lastWord = expW;
      h1 = c1; h2b = h2a; h2a = c2;
      if (fillN < 2) fillN++;
      check(outValid == expV, {tag, " R6 valid"}, int'(outValid), int'(expV));
      check($signed(outWord) == expW, {tag, " R3 word"}, int'($signed(outWord)), expW);
      if (outValid) check(outWord[0] == 1'b1, {tag, " R8 odd"}, int'(outWord[0]), 1);
    end else begin
      check(outValid == 1'b0, {tag, " R5 idle valid"}, int'(outValid), 0);
      check($signed(outWord) == lastWord, {tag, " R5 hold"}, int'($signed(outWord)), lastWord);
    end
    @(negedge clk);
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // R1: fill sequence, third sample is the first valid one
    step(1, 1, 1, "R1 fill1");
    step(1, 1, 1, "R1 fill2");
    step(1, 1, 1, "R1 fill3");

    // R7: constant ones then constant zeros
    for (int i = 0; i < 8; i++) begin
      step(1, 1, 1, "R7 ones");
      check($signed(outWord) == 1, "R7 ones const", int'($signed(outWord)), 1);
    end
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R7 settle");
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, "R7 zeros");
      check($signed(outWord) == -1, "R7 zeros const", int'($signed(outWord)), -1);
    end

    // R4: positive extreme: y2 = 1,0,1 with front bit 1 before the last
    step(1, 0, 1, "R4 pre");
    step(1, 1, 0, "R4 pre");
    step(1, 0, 1, "R4 max");
    check($signed(outWord) == 5, "R4 max word", int'($signed(outWord)), 5);
    // negative extreme: y2 = 0,1,0 with front bit 0 before the last
    step(1, 1, 0, "R4 pre");
    step(1, 0, 1, "R4 pre");
    step(1, 1, 0, "R4 min");
    check($signed(outWord) == -5, "R4 min word", int'($signed(outWord)), -5);

    // R5: idle cycles hold everything, history unchanged across the gap
    for (int i = 0; i < 4; i++) step(0, i[0], ~i[0], "R5 gap");
    step(1, 1, 1, "R5 resume");

    // random stream with gaps
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R3 rand");
    end

    // R9: reset mid-stream restarts the fill
    doReset();
    step(1, 1, 0, "R9 fill1");
    check(outValid == 1'b0, "R9 fill1 valid", int'(outValid), 0);
    step(0, 0, 0, "R9 gap");
    step(1, 0, 1, "R9 fill2");
    check(outValid == 1'b0, "R9 fill2 valid", int'(outValid), 0);
    step(1, 1, 1, "R9 fill3");
    check(outValid == 1'b1, "R9 fill3 valid", int'(outValid), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule